// File: doc/BRIEF.md
# UART Receive Buffer with Interrupt Request

This block sits between the byte output of a UART receiver and the port a host uses to read received data. Every received character arrives as a one-cycle strobe with its byte. The block stores it and drives one interrupt request line that tells the host when to come and collect data. A single enable input picks the storage mode. In queue mode a 16-entry first-in first-out byte store is used. In holding mode a single register is used.

In queue mode the request rises when the queue holds at least half its capacity. It also rises when data has been waiting with no new character and no host read for three character times. The block measures this idle time by counting a per-bit-time tick input. Once raised, the request stays high until the host has emptied the queue. In holding mode the request simply follows the presence of an unread byte. The host reads the head byte on `rd_data` and pops it with `rd_stb` in the same cycle. A byte that finds no free space is discarded and sets a sticky overrun flag. A change of the mode input discards all stored data.

Top module: `uart_rx_irq_buffer`

## Requirements
- R1: During and after reset, `empty` is 1, `irq` is 0, `overrun` is 0 and `rd_data` is 0.
- R2: While data is stored, `rd_data` shows the oldest stored byte. A cycle with `rd_stb` high removes it, so bytes are read in arrival order. In queue mode up to 16 bytes are held.
- R3: In queue mode `irq` goes high at the clock edge where the occupancy becomes 8 or more.
- R4: In queue mode, once `irq` is high it stays high until the queue is empty. It goes low at the edge that removes the last byte.
- R5: In queue mode, with data stored, `irq` goes high after the 30th `bit_tick` edge that has no accepted byte and no read in between. It stays low after only 29 such ticks.
- R6: In queue mode, an accepted byte or a read restarts the idle count from zero.
- R7: In holding mode capacity is one byte, `irq` equals "a byte is stored", and reading that byte clears `irq`.
- R8: A byte strobed while storage is full (16 bytes in queue mode, 1 in holding mode) with no read in the same cycle is discarded and sets `overrun`. `overrun` stays set until an `ovr_clr` cycle. A discard in the same cycle as `ovr_clr` wins.
- R9: A change of `fifo_en` discards all stored bytes. One edge later `empty` is 1 and `irq` is 0.
- R10: A read strobe while empty leaves `rd_data` at 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per serial bit time |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects holding mode |
| rd_stb | input | 1 | Host read; pops the byte shown on `rd_data` |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Oldest stored byte, 0 when empty |
| empty | output | 1 | No byte stored |
| irq | output | 1 | Receive interrupt request |
| overrun | output | 1 | Sticky flag: a byte was discarded |

## Verification
A wrong read or write pointer shows up at the first read after the error, as a byte out of order or a stale value on `rd_data`. A wrong occupancy count shows up as an early or late rise of `irq` at the 8th byte, or as an `irq` that drops before the queue is empty. A fault in the idle counter moves the rise of `irq` away from the 30th tick edge, so the bench probes the 29th and 30th ticks. A missed flush leaves `empty` low one edge after a mode change.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
    typedef logic [7:0] rx_byte_t;

    typedef enum logic {
        MODE_HOLD  = 1'b0,
        MODE_QUEUE = 1'b1
    } rx_mode_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxirq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic                       pop,
    input  rx_byte_t                   din,
    output rx_byte_t                   head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            end
            if (pop) begin
                st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            end
            case ({push, pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = (st_q.cnt == '0) ? '0 : st_q.mem[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/rxq_char_timer.sv
module rxq_char_timer #(
    parameter int TICKS_PER_CHAR = 10,
    parameter int CHARS          = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int LIMIT = TICKS_PER_CHAR * CHARS;
    localparam int TW    = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (restart || !run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == TW'(LIMIT - 1)) begin
                expire   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uart_rx_irq_buffer.sv
module uart_rx_irq_buffer
    import rxirq_pkg::*;
#(
    parameter int DEPTH          = 16,
    parameter int TICKS_PER_CHAR = 10,
    parameter int TIMEOUT_CHARS  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       bit_tick,
    input  logic       fifo_en,
    input  logic       rd_stb,
    input  logic       ovr_clr,
    output logic [7:0] rd_data,
    output logic       empty,
    output logic       irq,
    output logic       overrun
);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    typedef struct packed {
        rx_mode_e mode;
        logic     irq_lat;
        logic     ovr;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [CW-1:0] count;
    logic [CW-1:0] cnt_next;
    rx_byte_t      head;
    logic          mode_chg, full, push, pop, drop, expire, is_queue;

    assign is_queue = (st_q.mode == MODE_QUEUE);
    assign mode_chg = (rx_mode_e'(fifo_en) != st_q.mode);
    assign full     = is_queue ? (count >= CW'(DEPTH)) : (count != '0);
    assign pop      = rd_stb && (count != '0) && !mode_chg;
    assign push     = rx_valid && !mode_chg && (!full || pop);
    assign drop     = rx_valid && !mode_chg && !push;

    always_comb begin
        cnt_next = count;
        if (mode_chg)         cnt_next = '0;
        else if (push && !pop) cnt_next = count + 1'b1;
        else if (pop && !push) cnt_next = count - 1'b1;
    end

    always_comb begin
        st_d      = st_q;
        st_d.mode = rx_mode_e'(fifo_en);
        if (mode_chg || cnt_next == '0)
            st_d.irq_lat = 1'b0;
        else if (is_queue && (cnt_next >= CW'(HALF) || expire))
            st_d.irq_lat = 1'b1;
        if (drop)         st_d.ovr = 1'b1;
        else if (ovr_clr) st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: MODE_HOLD, irq_lat: 1'b0, ovr: 1'b0};
        else        st_q <= st_d;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (mode_chg),
        .push  (push),
        .pop   (pop),
        .din   (rx_byte),
        .head  (head),
        .count (count)
    );

    rxq_char_timer #(
        .TICKS_PER_CHAR (TICKS_PER_CHAR),
        .CHARS          (TIMEOUT_CHARS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (push || pop || mode_chg),
        .run     (is_queue && count != '0),
        .tick    (bit_tick),
        .expire  (expire)
    );

    assign rd_data = head;
    assign empty   = (count == '0);
    assign irq     = is_queue ? st_q.irq_lat : (count != '0);
    assign overrun = st_q.ovr;
endmodule

// File: rtl/uart_rx_irq_buffer_chk.sv
module uart_rx_irq_buffer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       fifo_en,
    input logic       rd_stb,
    input logic       ovr_clr,
    input logic [7:0] rd_data,
    input logic       empty,
    input logic       irq,
    input logic       overrun
);
    assert_hold_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !$past(fifo_en)) |-> (irq == !empty));

    assert_irq_until_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && $past(fifo_en) && $fell(irq)) |-> empty);

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> $past(ovr_clr));

    assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_valid));

    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_stb && !rx_valid) |=> (empty && rd_data == 8'h00));
endmodule

bind uart_rx_irq_buffer uart_rx_irq_buffer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .fifo_en  (fifo_en),
    .rd_stb   (rd_stb),
    .ovr_clr  (ovr_clr),
    .rd_data  (rd_data),
    .empty    (empty),
    .irq      (irq),
    .overrun  (overrun)
);

// File: tb/uart_rx_irq_buffer_test.sv
module uart_rx_irq_buffer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       bit_tick = 1'b0;
    logic       fifo_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic       empty, irq, overrun;

    int checks = 0;
    int failures = 0;
    int cap = 1;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    uart_rx_irq_buffer uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .bit_tick(bit_tick), .fifo_en(fifo_en), .rd_stb(rd_stb),
        .ovr_clr(ovr_clr), .rd_data(rd_data), .empty(empty), .irq(irq),
        .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: compares the head shown during each read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_stb) begin
            if (exp_q.size() > 0) chk("R2 read order", int'(rd_data), int'(exp_q.pop_front()));
            else                  chk("R10 empty read data", int'(rd_data), 0);
        end
    end

    task automatic send(input logic [7:0] b);
        if (exp_q.size() < cap) exp_q.push_back(b);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic rd();
        rd_stb = 1'b1;
        @(posedge clk); #1;
        rd_stb = 1'b0;
    endtask

    task automatic ticks(input int n);
        bit_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        bit_tick = 1'b0;
    endtask

    task automatic set_mode(input logic en);
        fifo_en = en;
        @(posedge clk); #1;
        exp_q.delete();
        cap = en ? 16 : 1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 empty", empty, 1);
        chk("R1 irq", irq, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // holding mode
        send(8'hA5);
        chk("R7 irq on valid", irq, 1);
        chk("R7 not empty", empty, 0);
        send(8'h3C);
        chk("R8 overrun hold", overrun, 1);
        rd();
        chk("R7 irq cleared by read", irq, 0);
        chk("R7 empty after read", empty, 1);
        rd();
        chk("R10 still empty", empty, 1);
        chk("R10 irq unchanged", irq, 0);
        chk("R8 overrun sticky", overrun, 1);
        ovr_clr = 1'b1;
        @(posedge clk); #1;
        ovr_clr = 1'b0;
        chk("R8 overrun cleared", overrun, 0);

        // queue mode, threshold
        set_mode(1'b1);
        for (int i = 0; i < 7; i++) send(8'h10 + 8'(i));
        chk("R3 irq below half", irq, 0);
        send(8'h17);
        chk("R3 irq at half", irq, 1);
        for (int i = 0; i < 7; i++) rd();
        chk("R4 irq held one left", irq, 1);
        chk("R4 not empty", empty, 0);
        rd();
        chk("R4 irq drop when empty", irq, 0);
        chk("R4 empty", empty, 1);

        // idle time-out
        send(8'h55);
        ticks(29);
        chk("R5 no irq at 29 ticks", irq, 0);
        ticks(1);
        chk("R5 irq at 30 ticks", irq, 1);
        send(8'h66);
        chk("R4 irq latched after byte", irq, 1);
        rd();
        chk("R4 irq latched one left", irq, 1);
        rd();
        chk("R4 irq cleared", irq, 0);

        // restart of idle count
        send(8'h71);
        ticks(20);
        send(8'h72);
        ticks(20);
        chk("R6 restart on byte", irq, 0);
        rd();
        ticks(20);
        chk("R6 restart on read", irq, 0);
        ticks(10);
        chk("R6 irq after full idle", irq, 1);
        rd();
        chk("R6 drained", irq, 0);

        // full queue
        for (int i = 0; i < 16; i++) send(8'hC0 + 8'(i));
        chk("R8 no overrun at 16", overrun, 0);
        send(8'hEE);
        chk("R8 overrun at 17th", overrun, 1);
        for (int i = 0; i < 16; i++) rd();
        chk("R2 empty after 16", empty, 1);
        chk("R2 irq after drain", irq, 0);

        // flush on mode change
        send(8'h01); send(8'h02); send(8'h03);
        set_mode(1'b0);
        chk("R9 empty after flush", empty, 1);
        chk("R9 irq after flush", irq, 0);
        rd();
        chk("R9 nothing left", empty, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule